// File: doc/BRIEF.md
# Four-phase request/acknowledge controller pair

This block holds two cooperating synchronous controllers on one clock: a requester and a worker. They are joined by a return-to-zero request/acknowledge pair of wires, `go` and `done`. A pulse or level on `start` gives the requester a job. The requester then raises `go` and keeps it high until the worker answers with `done`.

The worker leaves its idle state when it sees `go`. It spends a fixed number of processing cycles, set by the parameter `PROC_CYCLES` (at least 1), and then raises `done`. It holds `done` until `go` has fallen, and then goes back to idle. A transaction is finished only once both wires are low again. The requester shows this through `busy`, and it flags the moment of acknowledgement with a single-cycle `complete` strobe. The strobe is combinational on the live value of `done`.

Top module: `handshake_pair`

## Requirements
- R1: When the requester is idle, `start` high at a clock edge makes `go` high from that edge on.
- R2: Once high, `go` stays high until `done` has been high at a clock edge, and it falls at that edge.
- R3: `done` rises exactly `PROC_CYCLES`+1 clock edges after the edge at which `go` rose, and never while `go` is low.
- R4: Once high, `done` stays high while `go` is high, and it falls at the first edge that samples `go` low.
- R5: `complete` is high for exactly one cycle per transaction: the first cycle in which `done` is high while `go` is still high.
- R6: `busy` is high from the edge that raises `go` until the edge after `done` is sampled low; no new `go` rises while `done` is high.
- R7: `start` has no effect while `busy` is high; a held `start` begins the next transaction at the first edge after `busy` falls.
- R8: A synchronous reset (`rst` high at an edge) puts both controllers into idle, with `go`, `done`, `busy` and `complete` low, even in the middle of a transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both controllers |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Job request into the requester |
| busy | output | 1 | Requester has a transaction in progress |
| complete | output | 1 | One-cycle strobe when the acknowledge is first seen |
| go | output | 1 | Request wire, requester to worker |
| done | output | 1 | Acknowledge wire, worker to requester |

## Verification
The bench applies several patterns to `start`:
- A lone one-cycle pulse shows the plain four-phase sequence and its latency.
- A `start` level held over many cycles shows the spacing enforced between back-to-back transactions.
- Pulses that land in every phase of a running transaction show whether any of them leaks through.
- A reset applied while `done` is high shows that both sides abandon the exchange together, as opposed to one side being left mid-handshake.

// File: rtl/handshake_pair.sv
module handshake_pair #(
  parameter int PROC_CYCLES = 3,
  localparam int CW = (PROC_CYCLES > 1) ? $clog2(PROC_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic complete,
  output logic go,
  output logic done
);

  typedef enum logic [1:0] {RQ_IDLE, RQ_ASK, RQ_DRAIN} rq_t;
  typedef enum logic [1:0] {WK_IDLE, WK_WORK, WK_ACK} wk_t;

  rq_t rq;
  wk_t wk;
  logic [CW-1:0] cnt;
  logic last_cycle;

  assign go         = (rq == RQ_ASK);
  assign done       = (wk == WK_ACK);
  assign busy       = (rq != RQ_IDLE);
  assign complete   = go && done;
  assign last_cycle = (cnt == CW'(PROC_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rq <= RQ_IDLE;
    end else begin
      case (rq)
        RQ_IDLE:  if (start && !done) rq <= RQ_ASK;
        RQ_ASK:   if (done) rq <= RQ_DRAIN;
        RQ_DRAIN: if (!done) rq <= RQ_IDLE;
        default:  rq <= RQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wk  <= WK_IDLE;
      cnt <= '0;
    end else begin
      case (wk)
        WK_IDLE: if (go) begin
          wk  <= WK_WORK;
          cnt <= '0;
        end
        WK_WORK: begin
          if (last_cycle) wk <= WK_ACK;
          else cnt <= cnt + 1'b1;
        end
        WK_ACK:  if (!go) wk <= WK_IDLE;
        default: wk <= WK_IDLE;
      endcase
    end
  end

  assert_go_hold_R2: assert property (@(posedge clk) disable iff (rst)
    go && !done |=> go);
  assert_go_release_R2: assert property (@(posedge clk) disable iff (rst)
    go && done |=> !go);
  assert_done_needs_go_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> go);
  assert_done_hold_R4: assert property (@(posedge clk) disable iff (rst)
    done && go |=> done);
  assert_complete_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    complete |=> !complete);
  assert_no_early_go_R6: assert property (@(posedge clk) disable iff (rst)
    !go && done |=> !go);
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> !go && !done && !busy);

endmodule

// File: tb/handshake_pair_tb.sv
`timescale 1ns/100ps
module handshake_pair_tb_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, complete, go, done;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t = -1;
  int go_rise_cyc = -1;
  logic go_q = 1'b0, done_q = 1'b0, rst_q = 1'b1;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  handshake_pair #(.PROC_CYCLES(N)) dut_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .complete(complete), .go(go), .done(done)
  );

  // Timing model: t counts edges since the request was accepted, -1 when idle
  always @(posedge clk) begin
    cyc++;
    if (rst) t = -1;
    else if (t == -1) begin
      if (start) t = 0;
    end else if (t == N + 3) t = -1;
    else t++;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk("R1/R2", "go", go, (t >= 0 && t <= N + 1));
      chk("R3/R4", "done", done, (t >= N + 1 && t <= N + 2));
      chk("R5", "complete", complete, (t == N + 1));
      chk("R6/R7", "busy", busy, (t >= 0));
      if (rst_q) chk("R8", "reset idle", go | done | busy | complete, 1'b0);
      if (go && !go_q && !rst) go_rise_cyc = cyc;
      if (done && !done_q && !rst) begin
        checks++;
        if (cyc - go_rise_cyc != N + 1) begin
          errors++;
          $display("FAIL R3 latency: actual %0d expected %0d", cyc - go_rise_cyc, N + 1);
        end
      end
      go_q = go; done_q = done; rst_q = rst;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // lone pulse
    start = 1'b1; idle(1); start = 1'b0;
    idle(N + 8);
    // held start: back-to-back transactions
    start = 1'b1; idle(3 * (N + 5) + 2); start = 1'b0;
    idle(N + 8);
    // pulses in every phase of a running transaction (R7)
    start = 1'b1; idle(1); start = 1'b0;
    for (int k = 0; k < N + 3; k++) begin
      start = 1'b1; idle(1); start = 1'b0; idle(1);
    end
    idle(N + 8);
    // reset while done is high (R8)
    start = 1'b1; idle(1); start = 1'b0;
    idle(N + 2);
    rst = 1'b1; idle(2); rst = 1'b0;
    idle(3);
    start = 1'b1; idle(1); start = 1'b0;
    idle(N + 8);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    finished = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule